// File: doc/BRIEF.md
# Acquire/Release Ordering Gate

This block sits between an in-order core and the memory issue port. It decides, cycle by cycle, whether the operation at the head of the core's stream may go to memory. The stream carries three kinds of operation: plain loads and stores, acquires, and releases. The ordering is one-sided in each direction:

- An acquire holds back everything that comes after it until it completes. It does not wait for anything that came before it.
- A release waits for everything before it to complete. Later plain accesses and acquires do not wait for it.

A full fence would block in both directions. This gate blocks only in the direction each synchronisation kind needs.

The gate keeps three trackers:

- a counter of plain accesses that are in flight;
- a flag for an acquire that has been issued and has not completed;
- a flag for a release that has been issued and has not completed.

Memory returns one completion pulse per finished operation. Each pulse carries a class tag, and the tag selects which tracker it retires. The operation kind and address pass straight through to memory. The gate adds no cycle of latency to an allowed operation. An `idle` output is high when every tracker is empty.

Top module: `rc_order_gate`

## Requirements
- R1: Synchronous active-high reset empties all trackers. In the cycle after reset, `idle` is 1 and a plain access is accepted at once.
- R2: When an operation is allowed, `mem_valid` equals `core_valid` and `core_ready` equals `mem_ready`. `mem_kind` and `mem_addr` always equal `core_kind` and `core_addr`. When an operation is not allowed, both `mem_valid` and `core_ready` are 0.
- R3: Plain accesses (kind 2'b00) issue while others are outstanding, up to MAX_OUT in flight. At MAX_OUT they stall. When an issue and a plain completion fall in the same cycle, the count is unchanged.
- R4: An acquire (kind 2'b01) issues even while plain accesses or a release are still outstanding.
- R5: Once an acquire is issued, no operation of any kind is allowed until a completion tagged acquire (2'b01) arrives. Issue is allowed again in the cycle after that pulse.
- R6: A release (kind 2'b10) is held until the plain outstanding count is zero.
- R7: A release is held while an earlier release has not completed. A completion tagged release (2'b10) retires it, and the effect is visible in the next cycle.
- R8: Plain accesses and acquires issue while a release is outstanding.
- R9: `idle` is 1 exactly when no plain access, acquire or release is outstanding.
- R10: Kind code 2'b11 is reserved. Such an operation is never accepted or sent. A completion tagged 2'b11 changes no tracker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_valid | input | 1 | Core presents an operation |
| core_kind | input | 2 | 00 plain, 01 acquire, 10 release, 11 reserved |
| core_addr | input | AW | Operation address |
| core_ready | output | 1 | Operation accepted this cycle |
| mem_valid | output | 1 | Operation offered to memory |
| mem_kind | output | 2 | Kind forwarded to memory |
| mem_addr | output | AW | Address forwarded to memory |
| mem_ready | input | 1 | Memory takes the offered operation |
| done_valid | input | 1 | Completion pulse |
| done_kind | input | 2 | Class tag of the completing operation |
| idle | output | 1 | All trackers empty |

## Verification
The main stimulus is a single table-driven stream. In it:

- Plain accesses pile up to the limit with releases queued behind them. This separates a release that waits on the plain count from one that does not.
- An acquire is issued over outstanding plain accesses, and then later operations of each kind are offered. This shows the acquire blocks only forward in program order.
- Back-to-back releases, with plain accesses and acquires slipped between them, separate release-to-release ordering from blocking of later accesses, which must not happen.
- Same-cycle issue and completion, and reserved-tag pulses, show whether the tracker arithmetic holds.

A directed reset in the middle of activity follows the table.

// File: rtl/rc_order_pkg.sv
package rc_order_pkg;

    typedef enum logic [1:0] {
        OP_PLAIN = 2'b00,
        OP_ACQ   = 2'b01,
        OP_REL   = 2'b10,
        OP_RSVD  = 2'b11
    } op_kind_e;

    typedef struct packed {
        logic plain_full;
        logic plain_zero;
        logic acq_pend;
        logic rel_pend;
    } track_view_t;

    function automatic logic kind_allowed(op_kind_e k, track_view_t t);
        logic ok;
        if (t.acq_pend) begin
            ok = 1'b0;
        end else begin
            case (k)
                OP_PLAIN: ok = !t.plain_full;
                OP_ACQ:   ok = 1'b1;
                OP_REL:   ok = t.plain_zero && !t.rel_pend;
                default:  ok = 1'b0;
            endcase
        end
        return ok;
    endfunction

endpackage

// File: rtl/rc_plain_counter.sv
module rc_plain_counter #(
    parameter int MAX_OUT = 3,
    localparam int CW = $clog2(MAX_OUT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          zero
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (inc && !dec) begin
            count <= count + CW'(1);
        end else if (dec && !inc && count != '0) begin
            count <= count - CW'(1);
        end
    end

    assign full = (count == CW'(MAX_OUT));
    assign zero = (count == '0);

    // issue side must never push the counter past its limit
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (inc && !dec) |-> (count != CW'(MAX_OUT)));

    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        (inc && !dec) |=> (count == $past(count) + CW'(1)));

    assert_count_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (inc && dec) |=> $stable(count));

endmodule

// File: rtl/rc_pend_flag.sv
module rc_pend_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic pend
);

    always_ff @(posedge clk) begin
        if (rst)      pend <= 1'b0;
        else if (set) pend <= 1'b1;
        else if (clr) pend <= 1'b0;
    end

    assert_set_visible_R5: assert property (@(posedge clk) disable iff (rst)
        set |=> pend);

    assert_clear_visible_R7: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !pend);

endmodule

// File: rtl/rc_issue_gate.sv
module rc_issue_gate
    import rc_order_pkg::*;
(
    input  logic        core_valid,
    input  logic [1:0]  core_kind,
    input  logic        mem_ready,
    input  track_view_t view,
    output logic        mem_valid,
    output logic        core_ready,
    output logic        fire
);

    logic allow;

    always_comb begin
        allow      = kind_allowed(op_kind_e'(core_kind), view);
        mem_valid  = core_valid && allow;
        core_ready = mem_ready && allow;
        fire       = mem_valid && mem_ready;
    end

endmodule

// File: rtl/rc_order_gate.sv
module rc_order_gate
    import rc_order_pkg::*;
#(
    parameter int AW      = 16,
    parameter int MAX_OUT = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          core_valid,
    input  logic [1:0]    core_kind,
    input  logic [AW-1:0] core_addr,
    output logic          core_ready,
    output logic          mem_valid,
    output logic [1:0]    mem_kind,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ready,
    input  logic          done_valid,
    input  logic [1:0]    done_kind,
    output logic          idle
);

    localparam int CW = $clog2(MAX_OUT + 1);

    logic          fire;
    logic          plain_full, plain_zero, acq_pend, rel_pend;
    logic [CW-1:0] plain_count;
    track_view_t   view;

    logic iss_plain, iss_acq, iss_rel;
    logic fin_plain, fin_acq, fin_rel;

    always_comb begin
        iss_plain = fire && (op_kind_e'(core_kind) == OP_PLAIN);
        iss_acq   = fire && (op_kind_e'(core_kind) == OP_ACQ);
        iss_rel   = fire && (op_kind_e'(core_kind) == OP_REL);
        fin_plain = done_valid && (op_kind_e'(done_kind) == OP_PLAIN);
        fin_acq   = done_valid && (op_kind_e'(done_kind) == OP_ACQ);
        fin_rel   = done_valid && (op_kind_e'(done_kind) == OP_REL);
        view      = '{plain_full: plain_full, plain_zero: plain_zero,
                      acq_pend: acq_pend, rel_pend: rel_pend};
    end

    rc_plain_counter #(.MAX_OUT(MAX_OUT)) u_plain (
        .clk(clk), .rst(rst), .inc(iss_plain), .dec(fin_plain),
        .count(plain_count), .full(plain_full), .zero(plain_zero)
    );

    rc_pend_flag u_acq (
        .clk(clk), .rst(rst), .set(iss_acq), .clr(fin_acq), .pend(acq_pend)
    );

    rc_pend_flag u_rel (
        .clk(clk), .rst(rst), .set(iss_rel), .clr(fin_rel), .pend(rel_pend)
    );

    rc_issue_gate u_gate (
        .core_valid(core_valid), .core_kind(core_kind), .mem_ready(mem_ready),
        .view(view), .mem_valid(mem_valid), .core_ready(core_ready), .fire(fire)
    );

    assign mem_kind = core_kind;
    assign mem_addr = core_addr;
    assign idle     = plain_zero && !acq_pend && !rel_pend;

    assert_acq_blocks_all_R5: assert property (@(posedge clk) disable iff (rst)
        acq_pend |-> !mem_valid);

    assert_rel_after_drain_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && core_kind == 2'b10) |-> (plain_count == '0));

    assert_rel_in_order_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && core_kind == 2'b10) |-> !rel_pend);

    assert_ready_needs_mem_R2: assert property (@(posedge clk) disable iff (rst)
        core_ready |-> mem_ready);

    assert_rsvd_never_sent_R10: assert property (@(posedge clk) disable iff (rst)
        (core_kind == 2'b11) |-> (!mem_valid && !core_ready));

    assert_idle_still_R9: assert property (@(posedge clk) disable iff (rst)
        (idle && !fire) |=> idle);

endmodule

// File: tb/rc_order_gate_test.sv
module rc_order_gate_test;

    localparam int AW = 16;
    localparam int N  = 25;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          core_valid = 1'b0;
    logic [1:0]    core_kind = 2'b00;
    logic [AW-1:0] core_addr = '0;
    logic          core_ready, mem_valid;
    logic [1:0]    mem_kind;
    logic [AW-1:0] mem_addr;
    logic          mem_ready = 1'b0;
    logic          done_valid = 1'b0;
    logic [1:0]    done_kind = 2'b00;
    logic          idle;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rc_order_gate #(.AW(AW), .MAX_OUT(3)) uut (
        .clk(clk), .rst(rst), .core_valid(core_valid), .core_kind(core_kind),
        .core_addr(core_addr), .core_ready(core_ready), .mem_valid(mem_valid),
        .mem_kind(mem_kind), .mem_addr(mem_addr), .mem_ready(mem_ready),
        .done_valid(done_valid), .done_kind(done_kind), .idle(idle)
    );

    // {cv, kind[1:0], mr, dv, dk[1:0], exp_ready, exp_mvalid, exp_idle}
    localparam logic [9:0] TBL [N] = '{
        10'b0_00_0_0_00_001, //  0 R1 nothing offered, idle
        10'b1_00_1_0_00_111, //  1 R1 plain accepted straight after reset
        10'b1_00_0_0_00_010, //  2 R2 memory stalls, ready follows mem_ready
        10'b1_00_1_0_00_110, //  3 R3 second plain while one in flight
        10'b1_10_1_0_00_000, //  4 R6 release held by two plain
        10'b1_01_1_0_00_110, //  5 R4 acquire passes outstanding plain
        10'b1_00_1_0_00_000, //  6 R5 plain blocked by acquire
        10'b1_10_1_1_01_000, //  7 R5 acquire done this cycle, still blocked
        10'b1_00_1_0_00_110, //  8 R5 open again; third plain
        10'b1_00_1_0_00_000, //  9 R3 limit reached
        10'b1_00_1_1_00_000, // 10 R3 still full in completion cycle
        10'b1_00_1_1_00_110, // 11 R3 issue and completion together
        10'b0_00_0_1_00_000, // 12 R3 drain one
        10'b1_11_1_1_00_000, // 13 R10 reserved kind never sent
        10'b1_10_1_0_00_111, // 14 R6 release after drain
        10'b1_10_1_0_00_000, // 15 R7 second release waits for first
        10'b1_00_1_0_00_110, // 16 R8 plain passes pending release
        10'b1_01_1_0_00_110, // 17 R8 acquire passes pending release
        10'b0_00_0_1_11_000, // 18 R10 reserved tag retires nothing
        10'b0_00_0_1_01_000, // 19 R5 acquire completes
        10'b1_10_1_1_10_000, // 20 R6 release blocked by plain
        10'b0_00_0_1_00_000, // 21 R6 plain drains
        10'b1_10_1_0_00_111, // 22 R7 release after first retired
        10'b0_00_0_1_10_000, // 23 R7 release completes
        10'b0_00_0_0_00_001  // 24 R9 all empty again
    };

    localparam int REQ [N] = '{1,1,2,3,6,4,5,5,5,3,3,3,3,10,6,7,8,8,10,5,6,6,7,7,9};

    task automatic check(input bit ok, input int req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL R0 watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < N; i++) begin
            core_valid = TBL[i][9];
            core_kind  = TBL[i][8:7];
            mem_ready  = TBL[i][6];
            done_valid = TBL[i][5];
            done_kind  = TBL[i][4:3];
            core_addr  = AW'(16'h1000 + i);
            #1;
            check(core_ready == TBL[i][2], REQ[i], "core_ready", core_ready, TBL[i][2]);
            check(mem_valid == TBL[i][1], REQ[i], "mem_valid", mem_valid, TBL[i][1]);
            check(idle == TBL[i][0], REQ[i], "idle", idle, TBL[i][0]);
            // R2 pass-through of kind and address
            check(mem_addr == core_addr && mem_kind == core_kind, 2, "passthrough",
                  mem_addr, core_addr);
            @(negedge clk);
        end

        // R1: reset in the middle of activity
        done_valid = 1'b0; mem_ready = 1'b1; core_valid = 1'b1;
        core_kind = 2'b00;
        @(negedge clk);
        core_kind = 2'b01;
        @(negedge clk);
        core_valid = 1'b0;
        #1;
        check(idle == 1'b0, 1, "busy before reset", idle, 0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        core_valid = 1'b1; core_kind = 2'b10;
        #1;
        check(idle == 1'b1, 1, "idle after reset", idle, 1);
        check(core_ready == 1'b1, 1, "release free after reset", core_ready, 1);
        @(negedge clk);
        core_valid = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule